// File: doc/BRIEF.md
# Maskable Interrupt Source Aggregator

This block gathers 64 interrupt request lines into one summary interrupt. Each hardware line can be masked per source. A global mask-all control can disable every hardware source at once. Software can also inject a request on any source through force bits. Forced requests ignore the mask, so software can schedule its own interrupts or exercise a handler during debug.

Software reaches the block through a plain synchronous register port with byte offsets. Every register is a 32-bit word, and each 64-bit field is split into a high word (sources 63..32) and a low word (sources 31..0). The block drives the summary interrupt and a 64-bit masked request vector. Those outputs feed a downstream arbiter. Arbitration and vectoring are not part of this block. Read data returns one cycle after the read strobe.

The register port is a control interface, so it carries no valid/ready handshake. A read or a write is taken in every cycle in which its strobe is high, and the port never applies back-pressure.

Top module: `irq_aggregator`

## Requirements
- R1: The force words at offsets 0x10 (sources 63..32) and 0x14 (sources 31..0) read back exactly the value last written, and both are zero after reset.
- R2: A source whose force bit is 1 shows as 1 in `req_vec`, and sets `irq`, whatever the state of its mask bit or of mask-all.
- R3: A hardware request reaches `req_vec` only when that source's mask bit is 0. In the mask words at 0x08 (high) and 0x0C (low), 1 means masked.
- R4: Bit n of the pending words (0x00 high, 0x04 low) equals `hw_req[n] | force[n]` as sampled one cycle earlier, even when source n is masked.
- R5: Bit 0 of the mask word at 0x0C is mask-all. While it is 1, the other 63 mask bits read as ones, and writes to either mask word cannot clear them.
- R6: Clearing mask-all leaves the other 63 mask bits at one until software writes new values to them.
- R7: After reset, both mask words read 0xFFFFFFFF, both force words read 0, and `irq` and `req_vec` are 0.
- R8: `irq` and `req_vec` are registered. Each cycle's inputs and register state appear on them after one clock edge, and `irq` is the OR of `req_vec`.
- R9: Writes to the pending offsets 0x00 and 0x04 are ignored. They leave the mask words and force words unchanged.
- R10: `rd_data` is updated at the clock edge where `rd_en` is high and reads are not destructive. An offset outside 0x00..0x14 reads as zero.
- R11: Bit 0 of `req_vec` and bit 0 of the pending low word always read 0, because that position belongs to mask-all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 64 | Hardware request lines, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq | output | 1 | Summary interrupt |
| req_vec | output | 64 | Masked request vector |

## Verification
The bench runs sparse random hardware requests against random mask values and random force values. This separates the two paths into `req_vec`: the hardware path, which passes through the mask, and the force path, which does not. In that mix, a mask bit that is set while the same source's force bit is also set tells a mask-respecting force path apart from a correct one. A masked hardware line that still shows in the pending word tells raw reporting apart from masked reporting. Directed sequences then set mask-all, write the mask words while it is held and afterwards clear it. These show whether the mask ones are forced while mask-all is held and whether they are kept after it is cleared. Writes to the pending offsets and reads of unmapped offsets check that those accesses change no register and return zero.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int WORD_W = 32;
  parameter int ADDR_W = 5;
  localparam int NUM_SRC = 2 * WORD_W;

  localparam logic [ADDR_W-1:0] OFF_PEND_HI  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_FORCE_HI = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_FORCE_LO = 5'h14;

  typedef struct packed {
    logic hi;
    logic lo;
  } word_sel_t;
endpackage

// File: rtl/irq_force_regs.sv
module irq_force_regs
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  word_sel_t          wr_sel,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] force_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= '0;
    end else begin
      if (wr_sel.hi) force_q[NUM_SRC-1:WORD_W] <= wr_data;
      if (wr_sel.lo) force_q[WORD_W-1:0]       <= wr_data;
    end
  end

  assert_force_hi_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel.hi |=> force_q[NUM_SRC-1:WORD_W] == $past(wr_data));
  assert_force_lo_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel.lo |=> force_q[WORD_W-1:0] == $past(wr_data));
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  word_sel_t          wr_sel,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] mask_nxt;

  always_comb begin
    mask_nxt = mask_q;
    if (wr_sel.hi) mask_nxt[NUM_SRC-1:WORD_W] = wr_data;
    if (wr_sel.lo) mask_nxt[WORD_W-1:0]       = wr_data;
    if (mask_nxt[0]) mask_nxt[NUM_SRC-1:1] = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_nxt;
  end

  assert_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[0] |-> (&mask_q[NUM_SRC-1:1]));
  assert_clear_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q[0]) && !$past(wr_sel.hi) && !$past(wr_sel.lo)) |-> (&mask_q));
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] force_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] req_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] req_nxt;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_ctl
      assign req_nxt[s] = 1'b0;
      always_ff @(posedge clk) begin
        pend_q[s] <= 1'b0;
        req_q[s]  <= 1'b0;
      end
    end else begin : g_line
      assign req_nxt[s] = (hw_req[s] & ~mask_q[s]) | force_q[s];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q[s] <= 1'b0;
          req_q[s]  <= 1'b0;
        end else begin
          pend_q[s] <= hw_req[s] | force_q[s];
          req_q[s]  <= req_nxt[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |req_nxt;
  end

  assert_force_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|force_q[NUM_SRC-1:1]) |=> irq_q);
  assert_req_in_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q & ~pend_q) == '0);
  assert_bit0_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q[0] && !pend_q[0]);
  assert_irq_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|req_q));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  rd_data,
  output logic               irq,
  output logic [NUM_SRC-1:0] req_vec
);
  word_sel_t          mask_sel, force_sel;
  logic [NUM_SRC-1:0] mask_q, force_q, pend_q;

  assign mask_sel.hi  = wr_en && (addr == OFF_MASK_HI);
  assign mask_sel.lo  = wr_en && (addr == OFF_MASK_LO);
  assign force_sel.hi = wr_en && (addr == OFF_FORCE_HI);
  assign force_sel.lo = wr_en && (addr == OFF_FORCE_LO);

  irq_mask_regs u_mask (
    .clk(clk), .rst_n(rst_n), .wr_sel(mask_sel), .wr_data(wr_data), .mask_q(mask_q)
  );

  irq_force_regs u_force (
    .clk(clk), .rst_n(rst_n), .wr_sel(force_sel), .wr_data(wr_data), .force_q(force_q)
  );

  irq_combine u_comb (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .mask_q(mask_q), .force_q(force_q),
    .pend_q(pend_q), .req_q(req_vec), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (addr)
        OFF_PEND_HI:  rd_data <= pend_q[NUM_SRC-1:WORD_W];
        OFF_PEND_LO:  rd_data <= pend_q[WORD_W-1:0];
        OFF_MASK_HI:  rd_data <= mask_q[NUM_SRC-1:WORD_W];
        OFF_MASK_LO:  rd_data <= mask_q[WORD_W-1:0];
        OFF_FORCE_HI: rd_data <= force_q[NUM_SRC-1:WORD_W];
        OFF_FORCE_LO: rd_data <= force_q[WORD_W-1:0];
        default:      rd_data <= '0;
      endcase
    end
  end

  assert_pend_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFF_PEND_HI || addr == OFF_PEND_LO))
      |=> ($stable(mask_q) && $stable(force_q)));
  assert_masked_hw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[NUM_SRC-1:1] == '1 && force_q == '0) |=> (req_vec == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  import irq_agg_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] hw_req = '0;
  logic               wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [WORD_W-1:0]  wr_data = '0;
  logic [WORD_W-1:0]  rd_data;
  logic               irq;
  logic [NUM_SRC-1:0] req_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [NUM_SRC-1:0] m_force, m_mask;

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .req_vec(req_vec)
  );

  function automatic logic [NUM_SRC-1:0] f_req(logic [NUM_SRC-1:0] h,
      logic [NUM_SRC-1:0] m, logic [NUM_SRC-1:0] f);
    logic [NUM_SRC-1:0] r;
    r = (h & ~m) | f;
    r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [NUM_SRC-1:0] f_pend(logic [NUM_SRC-1:0] h, logic [NUM_SRC-1:0] f);
    logic [NUM_SRC-1:0] p;
    p = h | f;
    p[0] = 1'b0;
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] f_read(logic [ADDR_W-1:0] a, logic [NUM_SRC-1:0] p);
    case (a)
      OFF_PEND_HI:  return p[NUM_SRC-1:WORD_W];
      OFF_PEND_LO:  return p[WORD_W-1:0];
      OFF_MASK_HI:  return m_mask[NUM_SRC-1:WORD_W];
      OFF_MASK_LO:  return m_mask[WORD_W-1:0];
      OFF_FORCE_HI: return m_force[NUM_SRC-1:WORD_W];
      OFF_FORCE_LO: return m_force[WORD_W-1:0];
      default:      return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [NUM_SRC-1:0] act, logic [NUM_SRC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [NUM_SRC-1:0] pend_m = '0;

  task automatic step(logic [NUM_SRC-1:0] h, bit w, bit r, logic [ADDR_W-1:0] a,
      logic [WORD_W-1:0] d, string rtag);
    logic [NUM_SRC-1:0] e_req;
    logic [WORD_W-1:0]  e_rd;
    hw_req = h; wr_en = w; rd_en = r; addr = a; wr_data = d;
    e_req = f_req(h, m_mask, m_force);
    e_rd  = f_read(a, pend_m);
    pend_m = f_pend(h, m_force);
    if (w) begin
      case (a)
        OFF_MASK_HI:  m_mask[NUM_SRC-1:WORD_W] = d;
        OFF_MASK_LO:  m_mask[WORD_W-1:0] = d;
        OFF_FORCE_HI: m_force[NUM_SRC-1:WORD_W] = d;
        OFF_FORCE_LO: m_force[WORD_W-1:0] = d;
        default: ;
      endcase
      if (m_mask[0]) m_mask = '1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R2 R3 R11 req_vec", req_vec, e_req);
    check("R8 irq", {63'd0, irq}, {63'd0, |e_req});
    if (r) check(rtag, {32'd0, rd_data}, {32'd0, e_rd});
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NUM_SRC-1:0] h;
    void'($urandom(32'd20240611));
    m_force = '0; m_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    check("R7 irq", {63'd0, irq}, '0);
    check("R7 req_vec", req_vec, '0);
    step('0, 0, 1, OFF_MASK_LO, '0, "R7 mask lo");
    step('0, 0, 1, OFF_MASK_HI, '0, "R7 mask hi");
    step('0, 0, 1, OFF_FORCE_HI, '0, "R7 force hi R1");
    step('0, 0, 1, OFF_FORCE_LO, '0, "R7 force lo R1");
    // R2 force bypasses full mask
    step('0, 1, 0, OFF_FORCE_HI, 32'h8000_0001, "");
    step('0, 0, 1, OFF_FORCE_HI, '0, "R1 force hi readback");
    step('0, 0, 1, OFF_PEND_HI, '0, "R4 pend hi forced");
    // R11 force bit 0 has no output effect
    step('0, 1, 0, OFF_FORCE_HI, '0, "");
    step('0, 1, 0, OFF_FORCE_LO, 32'h0000_0001, "");
    step('0, 0, 1, OFF_PEND_LO, '0, "R11 pend lo bit0");
    step('0, 1, 0, OFF_FORCE_LO, '0, "");
    // R4 masked hw still pending
    step({32'h0, 32'h0000_0010}, 0, 0, OFF_PEND_LO, '0, "");
    step('0, 0, 1, OFF_PEND_LO, '0, "R4 masked pending");
    // R6 clear mask-all, bits stay ones
    step('0, 1, 0, OFF_MASK_LO, 32'h0, "");
    step('0, 0, 1, OFF_MASK_HI, '0, "R6 mask hi kept");
    step('0, 0, 1, OFF_MASK_LO, '0, "R6 mask lo rewritten");
    step({32'h0000_0100, 32'h0}, 0, 0, OFF_MASK_HI, '0, "R6 hw still masked");
    step('0, 1, 0, OFF_MASK_HI, 32'h0000_0100, "");
    step({32'h0000_0100, 32'h0}, 0, 0, OFF_MASK_HI, '0, "R3 hw masked");
    step({32'h0000_0200, 32'h0}, 0, 0, OFF_MASK_HI, '0, "R3 hw open");
    // R5 mask-all blocks clearing
    step('0, 1, 0, OFF_MASK_LO, 32'h0000_0001, "");
    step('0, 1, 0, OFF_MASK_HI, 32'h0, "");
    step('0, 0, 1, OFF_MASK_HI, '0, "R5 mask hi held ones");
    step({32'hFFFF_FFFF, 32'hFFFF_FFFF}, 0, 0, OFF_MASK_HI, '0, "R5 all masked");
    // R9 pending read-only, R10 unmapped reads zero
    step('0, 1, 0, OFF_PEND_LO, 32'h0, "");
    step('0, 1, 0, OFF_PEND_HI, 32'h0, "");
    step('0, 0, 1, OFF_MASK_LO, '0, "R9 mask unchanged");
    step('0, 0, 1, 5'h18, '0, "R10 unmapped 0x18");
    step('0, 0, 1, 5'h1C, '0, "R10 unmapped 0x1C");
    step('0, 0, 1, 5'h02, '0, "R10 unmapped 0x02");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [WORD_W-1:0] d;
      bit w, r;
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      case ($urandom % 8)
        0: a = OFF_PEND_HI;  1: a = OFF_PEND_LO;
        2: a = OFF_MASK_HI;  3: a = OFF_MASK_LO;
        4: a = OFF_FORCE_HI; 5: a = OFF_FORCE_LO;
        6: a = 5'h18;        default: a = 5'h1C;
      endcase
      d = $urandom;
      if (a == OFF_FORCE_HI || a == OFF_FORCE_LO) d = d & $urandom & $urandom & $urandom;
      if (a == OFF_MASK_LO) d[0] = (($urandom % 8) == 0);
      w = (($urandom % 3) == 0);
      r = (($urandom % 2) == 0);
      step(h, w, r, a, d, "R1 R4 R10 random read");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule